// File: doc/BRIEF.md
# Root Port Link Bring-Up Sequencer

This block drives the power-on sequence of a serial link controller that acts as the root of its hierarchy. After a single start request it selects root mode on the controller, lets the controller out of power-down and then out of soft reset, and waits a fixed settle time. While link training is still disabled it asks for PHY initialisation and then asks software to program the address translation windows. It then pulses the external card reset (PERST#), turns link training on, and waits for the link to come up.

When the card reset pin is fitted, the block holds off config requests for a quiet period after link-up, then raises a ready flag. If the link does not come up within a timeout, it stops in an error state with link training off and raises a fail flag. All delays are counted in reference-clock cycles and set from a clock-frequency parameter in MHz and per-delay parameters in microseconds, so a test build can shorten them.

Top module: `rp_bringup_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, every output is low.
- R2: After `start_i`, `rc_mode_o` goes high in an earlier cycle than `pwr_rel_o`. Once set, it stays high until reset.
- R3: `rst_rel_o` goes high in a later cycle than `pwr_rel_o`. Both stay high until reset.
- R4: `phy_init_o` rises exactly SETTLE_US*CLK_MHZ cycles after `rst_rel_o` rises.
- R5: `train_en_o` stays low while reset is being released, while `phy_init_o` is high, and while `win_req_o` is high.
- R6: `win_req_o` rises in the cycle after `phy_done_i` is sampled high during the PHY request. `perst_o` stays low until `win_done_i` is sampled high during the window request.
- R7: With HAS_PERST=1, `perst_o` is high for exactly PERST_US*CLK_MHZ consecutive cycles. `train_en_o` rises in the same cycle that `perst_o` falls.
- R8: With HAS_PERST=1, `cfg_ready_o` rises QUIET_US*CLK_MHZ cycles after the clock edge at which `link_up_i` is first sampled high during training.
- R9: With HAS_PERST=0, `perst_o` never rises. `train_en_o` rises in the cycle after `win_done_i` is accepted. `cfg_ready_o` rises in the cycle after `link_up_i` is accepted.
- R10: If `link_up_i` is not seen within TIMEOUT_US*CLK_MHZ cycles of training, `fail_o` rises and `train_en_o` drops. `fail_o` and `cfg_ready_o` are never high together, and both stay high until reset whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begins the sequence from idle |
| phy_done_i | input | 1 | PHY initialisation finished |
| win_done_i | input | 1 | Software has programmed the address windows |
| link_up_i | input | 1 | Link-up indication from the controller |
| rc_mode_o | output | 1 | Root-mode device-type select |
| pwr_rel_o | output | 1 | Power-down release |
| rst_rel_o | output | 1 | Soft-reset release |
| phy_init_o | output | 1 | Request PHY initialisation |
| win_req_o | output | 1 | Request address-window programming |
| perst_o | output | 1 | Card reset, high means asserted |
| train_en_o | output | 1 | Link-training enable |
| cfg_ready_o | output | 1 | Config requests allowed |
| fail_o | output | 1 | Link-up timeout occurred |

## Verification
The assertions assume that handshake inputs matter only in the state that waits for them. `phy_done_i` is read only during the PHY request, `win_done_i` only during the window request, and `link_up_i` only during training. Values of these inputs at any other time must leave the output sequence unchanged. The stimulus raises each handshake only after the matching request is visible on the outputs, and holds `link_up_i` low until training is enabled. The timeout run also raises `link_up_i` after the failure, to show that the error state does not react to it. The card-reset width check counts consecutive high cycles of `perst_o` in the checker, so the width can be checked for any parameter value.

// File: rtl/rpb_pkg.sv
package rpb_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_MODE,
        ST_PWR,
        ST_SETTLE,
        ST_PHY,
        ST_WIN,
        ST_PERST,
        ST_TRAIN,
        ST_QUIET,
        ST_READY,
        ST_FAIL
    } rpb_state_e;

    typedef struct packed {
        logic rc_mode;
        logic pwr_rel;
        logic rst_rel;
        logic phy_init;
        logic win_req;
        logic perst;
        logic train_en;
        logic cfg_ready;
        logic fail;
    } rpb_ctl_t;

    function automatic int unsigned us_to_cyc(input int unsigned mhz,
                                              input int unsigned us);
        return mhz * us;
    endfunction

    function automatic logic is_timed(input rpb_state_e s);
        return (s == ST_SETTLE) || (s == ST_PERST) ||
               (s == ST_TRAIN)  || (s == ST_QUIET);
    endfunction

    function automatic int unsigned max2(input int unsigned a,
                                         input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/rpb_timer.sv
module rpb_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rpb_fsm.sv
module rpb_fsm
    import rpb_pkg::*;
#(
    parameter bit HAS_PERST = 1'b1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  logic       phy_done_i,
    input  logic       win_done_i,
    input  logic       link_up_i,
    input  logic       tmr_zero_i,
    output rpb_state_e state_q,
    output rpb_state_e state_d
);
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_MODE;
            ST_MODE:   state_d = ST_PWR;
            ST_PWR:    state_d = ST_SETTLE;
            ST_SETTLE: if (tmr_zero_i) state_d = ST_PHY;
            ST_PHY:    if (phy_done_i) state_d = ST_WIN;
            ST_WIN:    if (win_done_i) state_d = HAS_PERST ? ST_PERST : ST_TRAIN;
            ST_PERST:  if (tmr_zero_i) state_d = ST_TRAIN;
            ST_TRAIN: begin
                if (link_up_i)       state_d = HAS_PERST ? ST_QUIET : ST_READY;
                else if (tmr_zero_i) state_d = ST_FAIL;
            end
            ST_QUIET:  if (tmr_zero_i) state_d = ST_READY;
            ST_READY:  state_d = ST_READY;
            ST_FAIL:   state_d = ST_FAIL;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end
endmodule

// File: rtl/rpb_outdec.sv
module rpb_outdec
    import rpb_pkg::*;
(
    input  rpb_state_e state_i,
    output rpb_ctl_t   ctl_o
);
    always_comb begin
        ctl_o           = '0;
        ctl_o.rc_mode   = (state_i != ST_IDLE);
        ctl_o.pwr_rel   = (state_i != ST_IDLE) && (state_i != ST_MODE);
        ctl_o.rst_rel   = ctl_o.pwr_rel && (state_i != ST_PWR);
        ctl_o.phy_init  = (state_i == ST_PHY);
        ctl_o.win_req   = (state_i == ST_WIN);
        ctl_o.perst     = (state_i == ST_PERST);
        ctl_o.train_en  = (state_i == ST_TRAIN) || (state_i == ST_QUIET) ||
                          (state_i == ST_READY);
        ctl_o.cfg_ready = (state_i == ST_READY);
        ctl_o.fail      = (state_i == ST_FAIL);
    end
endmodule

// File: rtl/rp_bringup_seq.sv
module rp_bringup_seq
    import rpb_pkg::*;
#(
    parameter int unsigned CLK_MHZ    = 100,
    parameter int unsigned SETTLE_US  = 1000,
    parameter int unsigned PERST_US   = 100,
    parameter int unsigned QUIET_US   = 100000,
    parameter int unsigned TIMEOUT_US = 200000,
    parameter bit          HAS_PERST  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic start_i,
    input  logic phy_done_i,
    input  logic win_done_i,
    input  logic link_up_i,
    output logic rc_mode_o,
    output logic pwr_rel_o,
    output logic rst_rel_o,
    output logic phy_init_o,
    output logic win_req_o,
    output logic perst_o,
    output logic train_en_o,
    output logic cfg_ready_o,
    output logic fail_o
);
    localparam int unsigned SETTLE_CYC  = us_to_cyc(CLK_MHZ, SETTLE_US);
    localparam int unsigned PERST_CYC   = us_to_cyc(CLK_MHZ, PERST_US);
    localparam int unsigned QUIET_CYC   = us_to_cyc(CLK_MHZ, QUIET_US);
    localparam int unsigned TIMEOUT_CYC = us_to_cyc(CLK_MHZ, TIMEOUT_US);
    localparam int unsigned MAX_CYC     =
        max2(max2(SETTLE_CYC, PERST_CYC), max2(QUIET_CYC, TIMEOUT_CYC));
    localparam int unsigned TW          = $clog2(MAX_CYC + 1);

    rpb_state_e   state_q, state_d;
    rpb_ctl_t     ctl;
    logic         tmr_zero;
    logic         tmr_load;
    logic [TW-1:0] tmr_val;

    rpb_fsm #(.HAS_PERST(HAS_PERST)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .start_i    (start_i),
        .phy_done_i (phy_done_i),
        .win_done_i (win_done_i),
        .link_up_i  (link_up_i),
        .tmr_zero_i (tmr_zero),
        .state_q    (state_q),
        .state_d    (state_d)
    );

    // A timed state lasts N cycles: the timer is loaded with N-1 on entry.
    assign tmr_load = (state_d != state_q) && is_timed(state_d);

    always_comb begin
        unique case (state_d)
            ST_SETTLE: tmr_val = TW'(SETTLE_CYC - 1);
            ST_PERST:  tmr_val = TW'(PERST_CYC - 1);
            ST_TRAIN:  tmr_val = TW'(TIMEOUT_CYC - 1);
            ST_QUIET:  tmr_val = TW'(QUIET_CYC - 1);
            default:   tmr_val = '0;
        endcase
    end

    rpb_timer #(.W(TW)) u_tmr (
        .clk        (clk),
        .rst        (rst),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    rpb_outdec u_dec (
        .state_i (state_q),
        .ctl_o   (ctl)
    );

    assign rc_mode_o   = ctl.rc_mode;
    assign pwr_rel_o   = ctl.pwr_rel;
    assign rst_rel_o   = ctl.rst_rel;
    assign phy_init_o  = ctl.phy_init;
    assign win_req_o   = ctl.win_req;
    assign perst_o     = ctl.perst;
    assign train_en_o  = ctl.train_en;
    assign cfg_ready_o = ctl.cfg_ready;
    assign fail_o      = ctl.fail;
endmodule

// File: rtl/rpb_checker.sv
module rpb_checker #(
    parameter int unsigned PERST_CYC = 1,
    parameter int unsigned RW        = 8
) (
    input logic clk,
    input logic rst,
    input logic rc_mode,
    input logic pwr_rel,
    input logic rst_rel,
    input logic phy_init,
    input logic win_req,
    input logic perst,
    input logic train_en,
    input logic cfg_ready,
    input logic fail
);
    logic [RW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst || !perst)          run_q <= '0;
        else if (run_q != '1)       run_q <= run_q + 1'b1;
    end

    AST_MODE_FIRST: assert property (@(posedge clk) disable iff (rst)
        pwr_rel |-> rc_mode); // R2
    AST_RST_AFTER_PWR: assert property (@(posedge clk) disable iff (rst)
        rst_rel |-> pwr_rel); // R3
    AST_RELEASE_HELD: assert property (@(posedge clk) disable iff (rst)
        rst_rel |=> rst_rel); // R3
    AST_TRAIN_OFF_EARLY: assert property (@(posedge clk) disable iff (rst)
        (phy_init || win_req || perst) |-> !train_en); // R5
    AST_PERST_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $fell(perst) |-> (run_q == RW'(PERST_CYC))); // R7
    AST_TRAIN_ON_PERST_FALL: assert property (@(posedge clk) disable iff (rst)
        $fell(perst) |-> train_en); // R7
    AST_READY_FAIL_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(cfg_ready && fail)); // R10
    AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
        cfg_ready |=> cfg_ready); // R10
    AST_FAIL_STICKY: assert property (@(posedge clk) disable iff (rst)
        fail |=> (fail && !train_en)); // R10
endmodule

bind rp_bringup_seq rpb_checker #(
    .PERST_CYC (PERST_CYC),
    .RW        (TW)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .rc_mode   (rc_mode_o),
    .pwr_rel   (pwr_rel_o),
    .rst_rel   (rst_rel_o),
    .phy_init  (phy_init_o),
    .win_req   (win_req_o),
    .perst     (perst_o),
    .train_en  (train_en_o),
    .cfg_ready (cfg_ready_o),
    .fail      (fail_o)
);

// File: tb/rp_bringup_seq_test.sv
module rp_bringup_seq_test;
    localparam int MHZ  = 1;
    localparam int S_US = 20;
    localparam int P_US = 10;
    localparam int Q_US = 30;
    localparam int T_US = 50;
    localparam int SETTLE_C  = MHZ * S_US;
    localparam int PERST_C   = MHZ * P_US;
    localparam int QUIET_C   = MHZ * Q_US;
    localparam int TIMEOUT_C = MHZ * T_US;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 0, phy_done = 0, win_done = 0, link_up = 0;
    logic rc_mode, pwr_rel, rst_rel, phy_init, win_req, perst, train_en, ready, fail;
    logic n_start = 0, n_phy = 0, n_win = 0, n_link = 0;
    logic n_rc, n_pwr, n_rst, n_phyi, n_winr, n_perst, n_train, n_ready, n_fail;

    int nchk = 0;
    int nerr = 0;

    always #2 clk = ~clk;

    rp_bringup_seq #(.CLK_MHZ(MHZ), .SETTLE_US(S_US), .PERST_US(P_US),
        .QUIET_US(Q_US), .TIMEOUT_US(T_US), .HAS_PERST(1'b1)) uut (
        .clk(clk), .rst(rst), .start_i(start), .phy_done_i(phy_done),
        .win_done_i(win_done), .link_up_i(link_up), .rc_mode_o(rc_mode),
        .pwr_rel_o(pwr_rel), .rst_rel_o(rst_rel), .phy_init_o(phy_init),
        .win_req_o(win_req), .perst_o(perst), .train_en_o(train_en),
        .cfg_ready_o(ready), .fail_o(fail));

    rp_bringup_seq #(.CLK_MHZ(MHZ), .SETTLE_US(S_US), .PERST_US(P_US),
        .QUIET_US(Q_US), .TIMEOUT_US(T_US), .HAS_PERST(1'b0)) uut_np (
        .clk(clk), .rst(rst), .start_i(n_start), .phy_done_i(n_phy),
        .win_done_i(n_win), .link_up_i(n_link), .rc_mode_o(n_rc),
        .pwr_rel_o(n_pwr), .rst_rel_o(n_rst), .phy_init_o(n_phyi),
        .win_req_o(n_winr), .perst_o(n_perst), .train_en_o(n_train),
        .cfg_ready_o(n_ready), .fail_o(n_fail));

    task automatic chk(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nerr++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        rst = 1'b1;
        start = 0; phy_done = 0; win_done = 0; link_up = 0;
        n_start = 0; n_phy = 0; n_win = 0; n_link = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset",
            int'({rc_mode, pwr_rel, rst_rel, phy_init, win_req, perst, train_en, ready, fail}), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 outputs after reset",
            int'({rc_mode, pwr_rel, rst_rel, phy_init, win_req, perst, train_en, ready, fail,
                  n_rc, n_perst, n_train, n_ready}), 0);
    endtask

    // Runs from idle until training is visible; returns PERST width seen.
    task automatic run_to_train(output int pw);
        int t_mode = -1, t_pwr = -1, t_rst = -1, t_phy = -1;
        int early_train = 0;
        start = 1'b1;
        for (int i = 1; i < 200 && t_phy < 0; i++) begin
            @(negedge clk);
            if (rc_mode && t_mode < 0) t_mode = i;
            if (pwr_rel && t_pwr < 0)  t_pwr = i;
            if (rst_rel && t_rst < 0)  t_rst = i;
            if (phy_init && t_phy < 0) t_phy = i;
            if (train_en) early_train++;
        end
        start = 1'b0;
        chk("R2 mode before power release", int'(t_mode < t_pwr && t_mode > 0), 1);
        chk("R3 soft reset after power release", int'(t_pwr < t_rst && t_pwr > 0), 1);
        chk("R4 settle length", t_phy - t_rst, SETTLE_C);
        chk("R5 training off before PHY init", early_train, 0);
        repeat (3) @(negedge clk);
        chk("R6 waits for PHY done", int'({phy_init, win_req, train_en}), 3'b100);
        phy_done = 1'b1;
        @(negedge clk);
        phy_done = 1'b0;
        chk("R6 window request after PHY done", int'({phy_init, win_req, train_en}), 3'b010);
        repeat (4) @(negedge clk);
        chk("R6 no PERST before window done", int'({win_req, perst, train_en}), 3'b100);
        chk("R2 mode bits held", int'({rc_mode, pwr_rel, rst_rel}), 3'b111);
        win_done = 1'b1;
        @(negedge clk);
        win_done = 1'b0;
        pw = 0;
        while (perst && pw < 1000) begin
            chk("R5 training off during PERST", int'(train_en), 0);
            pw++;
            @(negedge clk);
        end
        chk("R7 training on as PERST falls", int'(train_en), 1);
    endtask

    task automatic t_main_perst();
        int pw, k;
        do_reset();
        run_to_train(pw);
        chk("R7 PERST width", pw, PERST_C);
        repeat (5) @(negedge clk);
        link_up = 1'b1;
        k = 0;
        do begin
            @(negedge clk);
            k++;
        end while (!ready && k < 1000);
        chk("R8 quiet time after link-up", k, QUIET_C + 1);
        chk("R10 no fail on success", int'(fail), 0);
        link_up = 1'b0;
        repeat (TIMEOUT_C + 5) @(negedge clk);
        chk("R10 ready held, link drop ignored", int'({ready, fail, train_en}), 3'b101);
    endtask

    task automatic t_timeout();
        int pw, k;
        do_reset();
        run_to_train(pw);
        k = 0;
        while (!fail && k < 1000) begin
            @(negedge clk);
            k++;
        end
        chk("R10 timeout length", k, TIMEOUT_C);
        chk("R10 fail state outputs", int'({fail, ready, train_en}), 3'b100);
        link_up = 1'b1;
        repeat (QUIET_C + 5) @(negedge clk);
        chk("R10 late link-up ignored", int'({fail, ready, train_en}), 3'b100);
        link_up = 1'b0;
    endtask

    task automatic t_no_perst();
        int seen_perst = 0;
        int k = 0;
        do_reset();
        n_start = 1'b1;
        while (!n_phyi && k < 200) begin
            @(negedge clk);
            k++;
            if (n_perst) seen_perst++;
        end
        n_start = 1'b0;
        n_phy = 1'b1;
        @(negedge clk);
        n_phy = 1'b0;
        chk("R9 window request", int'(n_winr), 1);
        n_win = 1'b1;
        @(negedge clk);
        n_win = 1'b0;
        if (n_perst) seen_perst++;
        chk("R9 training right after window done", int'(n_train), 1);
        chk("R9 PERST never asserted", seen_perst, 0);
        repeat (3) @(negedge clk);
        chk("R9 not ready before link-up", int'(n_ready), 0);
        n_link = 1'b1;
        @(negedge clk);
        chk("R9 ready one cycle after link-up", int'({n_ready, n_fail}), 2'b10);
        n_link = 1'b0;
    endtask

    initial begin
        #400000;
        nerr++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        t_reset();
        t_main_perst();
        t_timeout();
        t_no_perst();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule